// File: doc/BRIEF.md
# Wake Reason and Status Registers

This block keeps two read-only views of the wake inputs of a power-management controller. The first is a sticky reason register. It takes a snapshot of the on-key, hands-free power, alarm and charger-pin levels on the single-cycle power-up start strobe from the sequencer. It then keeps that snapshot until the next power-up start or a full reset. Firmware reads it to learn what woke the system, and when several sources were active together, every one of them is recorded.

The second is a live status register. It shows the present on-key, hands-free and alarm levels, a charger-present flag, two comparator outputs and an ADC busy flag. The charger-present flag follows a voltage-in-window indication, not the charger pin. So the two charger bits can legitimately differ.

Both registers sit behind a simple read port. A read request with an address returns data one cycle later. Addresses that map to neither register return zero.

Top module: `wake_status_regs`

## Requirements
- R1: On a clock edge where `pwrUpStart` is 1, the reason register loads bit 0 = `onKey`, bit 1 = `hfPwr`, bit 2 = `alarm` and bit 3 = `chgPin`, all sampled in that cycle. Every source that is high is set at once.
- R2: Between power-up start strobes, the reason register keeps its value whatever the wake inputs do.
- R3: A new power-up start replaces the whole reason register. A bit whose source is low at the new start reads 0, even if it was set before.
- R4: After reset, the reason register is 0 and `rdData` is 0.
- R5: Status bits 0, 1 and 2 show the present levels of `onKey`, `hfPwr` and `alarm`.
- R6: Status bit 3 equals `chgInWindow` and does not depend on `chgPin`. Reason bit 3 equals the captured `chgPin` and does not depend on `chgInWindow`.
- R7: Status bits 4 and 5 show `cmpOut[0]` and `cmpOut[1]`. Bit 6 shows `adcBusy`. Bit 7 reads 0. Reason bits 7 to 4 read 0.
- R8: A read with `rdEn` = 1 at a clock edge puts the selected value on `rdData` after that edge, for one cycle. When `rdEn` is 0 at an edge, `rdData` is 0 after it.
- R9: A read of any address other than `REASON_ADDR` (default 0x10) or `STATUS_ADDR` (default 0x11) returns 0.
- R10: A read of the reason register at the same edge as a power-up start returns the value held before that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low full reset (supply below power-on threshold) |
| onKey | input | 1 | On-key level |
| hfPwr | input | 1 | Hands-free power level |
| alarm | input | 1 | Real-time alarm level |
| chgPin | input | 1 | Charger input pin level |
| chgInWindow | input | 1 | Charger voltage inside the valid charging window |
| cmpOut | input | NUM_CMP (2) | Comparator outputs |
| adcBusy | input | 1 | ADC conversion in progress |
| pwrUpStart | input | 1 | Single-cycle power-up start strobe |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W (6) | Read address |
| rdData | output | DATA_W (8) | Read data, one cycle after request |

## Verification
A corrupted or wrongly reloaded reason register is hidden until a read, because it has no output of its own. The bench therefore reads it often, both between strobes and in the strobe cycle itself, so a bad capture or a missed hold shows on `rdData` within a few cycles. Status bit errors, such as a swapped charger source or a misplaced comparator, show on the next status read. Random input changes between reads make a stale or mismatched bit appear as a wrong value one cycle after the request.

// File: rtl/wake_regs_pkg.sv
package wake_regs_pkg;

  // number of wake sources held in the reason register
  localparam int NUM_SRC = 4;

  // bit positions shared by both registers for the first three sources
  localparam int BIT_ON    = 0;
  localparam int BIT_HF    = 1;
  localparam int BIT_ALARM = 2;
  localparam int BIT_CHG   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic captureEn;
    logic readReason;
    logic readStatus;
  } wakeStrobes_t;

endpackage

// File: rtl/wake_regs_ctrl.sv
module wake_regs_ctrl
  import wake_regs_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int REASON_ADDR = 'h10,
  parameter int STATUS_ADDR = 'h11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrUpStart,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output wakeStrobes_t      strb
);

  localparam logic [ADDR_W-1:0] REASON_A = ADDR_W'(REASON_ADDR);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

  always_comb begin
    strb            = '0;
    strb.captureEn  = pwrUpStart;
    strb.readReason = rdEn && (rdAddr == REASON_A);
    strb.readStatus = rdEn && (rdAddr == STATUS_A);
  end

  // R9: at most one register is selected per read
  p_single_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.readReason, strb.readStatus}));

  // R8: no register select without a read request
  p_sel_needs_rd_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> !(strb.readReason || strb.readStatus));

endmodule

// File: rtl/wake_regs_dp.sv
module wake_regs_dp
  import wake_regs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_CMP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  wakeStrobes_t       strb,
  input  logic               onKey,
  input  logic               hfPwr,
  input  logic               alarm,
  input  logic               chgPin,
  input  logic               chgInWindow,
  input  logic [NUM_CMP-1:0] cmpOut,
  input  logic               adcBusy,
  output logic [DATA_W-1:0]  rdData
);

  localparam int CMP_LSB = NUM_SRC;
  localparam int ADC_BIT = NUM_SRC + NUM_CMP;

  logic [NUM_SRC-1:0] srcVec;
  logic [NUM_SRC-1:0] reasonQ;
  logic [DATA_W-1:0]  statusVec;
  logic [NUM_CMP-1:0] cmpField;

  // wake-source vector sampled at capture
  always_comb begin
    srcVec            = '0;
    srcVec[BIT_ON]    = onKey;
    srcVec[BIT_HF]    = hfPwr;
    srcVec[BIT_ALARM] = alarm;
    srcVec[BIT_CHG]   = chgPin;
  end

  // comparator lanes placed one per bit
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign cmpField[g] = cmpOut[g];
  end

  // live status word
  always_comb begin
    statusVec                           = '0;
    statusVec[BIT_ON]                   = onKey;
    statusVec[BIT_HF]                   = hfPwr;
    statusVec[BIT_ALARM]                = alarm;
    statusVec[BIT_CHG]                  = chgInWindow;
    statusVec[CMP_LSB +: NUM_CMP]       = cmpField;
    statusVec[ADC_BIT]                  = adcBusy;
  end

  // sticky reason register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               reasonQ <= '0;
    else if (strb.captureEn) reasonQ <= srcVec;
  end

  // registered read data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strb.readReason) rdData <= DATA_W'(reasonQ);
    else if (strb.readStatus) rdData <= statusVec;
    else                      rdData <= '0;
  end

  // R1: capture loads the source levels seen at the strobe
  p_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureEn |=> reasonQ == $past({chgPin, alarm, hfPwr, onKey}));

  // R2: no strobe, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureEn |=> $stable(reasonQ));

  // R7: reason reads carry zeros above the source bits
  p_reason_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.readReason |=> rdData[DATA_W-1:NUM_SRC] == '0);

  // R8: idle or unmapped cycles give zero data
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.readReason || strb.readStatus) |=> rdData == '0);

endmodule

// File: rtl/wake_status_regs.sv
module wake_status_regs
  import wake_regs_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int NUM_CMP     = 2,
  parameter int REASON_ADDR = 'h10,
  parameter int STATUS_ADDR = 'h11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               onKey,
  input  logic               hfPwr,
  input  logic               alarm,
  input  logic               chgPin,
  input  logic               chgInWindow,
  input  logic [NUM_CMP-1:0] cmpOut,
  input  logic               adcBusy,
  input  logic               pwrUpStart,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData
);

  wakeStrobes_t strb;

  wake_regs_ctrl #(
    .ADDR_W(ADDR_W), .REASON_ADDR(REASON_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .pwrUpStart(pwrUpStart),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  wake_regs_dp #(.DATA_W(DATA_W), .NUM_CMP(NUM_CMP)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .onKey(onKey), .hfPwr(hfPwr), .alarm(alarm), .chgPin(chgPin),
    .chgInWindow(chgInWindow), .cmpOut(cmpOut), .adcBusy(adcBusy),
    .rdData(rdData)
  );

endmodule

// File: tb/wake_status_regs_tb.sv
module wake_status_regs_tb_top;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_REASON = 6'h10;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onKey = 0, hfPwr = 0, alarm = 0, chgPin = 0, chgInWindow = 0;
  logic [1:0] cmpOut = '0;
  logic adcBusy = 0, pwrUpStart = 0, rdEn = 0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [3:0] modelReason = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  wake_status_regs dut_i (
    .clk(clk), .rstN(rstN), .onKey(onKey), .hfPwr(hfPwr), .alarm(alarm),
    .chgPin(chgPin), .chgInWindow(chgInWindow), .cmpOut(cmpOut),
    .adcBusy(adcBusy), .pwrUpStart(pwrUpStart), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [7:0] expStatus();
    return {1'b0, adcBusy, cmpOut[1], cmpOut[0], chgInWindow, alarm, hfPwr, onKey};
  endfunction

  function automatic logic [7:0] expRead(logic en, logic [ADDR_W-1:0] a);
    if (!en) return 8'h00;
    if (a == A_REASON) return {4'h0, modelReason};
    if (a == A_STATUS) return expStatus();
    return 8'h00;
  endfunction

  task automatic check(logic [7:0] got, logic [7:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rdData=%02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compute expectation, check after posedge
  task automatic step(logic st, logic en, logic [ADDR_W-1:0] a, string tag);
    logic [7:0] exp;
    @(negedge clk);
    pwrUpStart = st; rdEn = en; rdAddr = a;
    exp = expRead(en, a);
    @(posedge clk);
    #2;
    check(rdData, exp, tag);
    if (st) modelReason = {chgPin, alarm, hfPwr, onKey};
    pwrUpStart = 0; rdEn = 0;
  endtask

  task automatic setIn(logic o, logic h, logic al, logic cp, logic win,
                       logic [1:0] c, logic adc);
    @(negedge clk);
    onKey = o; hfPwr = h; alarm = al; chgPin = cp; chgInWindow = win;
    cmpOut = c; adcBusy = adc;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    check(rdData, 8'h00, "R4 reset data");
    @(negedge clk) rstN = 1;
    step(0, 1, A_REASON, "R4 reason after reset");

    // R1: single source then several at once
    setIn(1, 0, 0, 0, 0, 2'b00, 0);
    step(1, 0, A_REASON, "R8 idle");
    step(0, 1, A_REASON, "R1 on-key only");
    setIn(1, 1, 1, 1, 1, 2'b00, 0);
    step(1, 0, '0, "R8 idle");
    step(0, 1, A_REASON, "R1 all sources");

    // R2: inputs change, no strobe
    setIn(0, 0, 0, 0, 0, 2'b11, 1);
    step(0, 1, A_REASON, "R2 hold");

    // R3: recapture with only alarm clears other bits
    setIn(0, 0, 1, 0, 0, 2'b00, 0);
    step(1, 0, '0, "R8 idle");
    step(0, 1, A_REASON, "R3 recapture");

    // R6: charger pin high, window low, and the reverse
    setIn(0, 0, 0, 1, 0, 2'b00, 0);
    step(1, 0, '0, "R8 idle");
    step(0, 1, A_STATUS, "R6 status ignores pin");
    step(0, 1, A_REASON, "R6 reason takes pin");
    setIn(0, 0, 0, 0, 1, 2'b00, 0);
    step(0, 1, A_STATUS, "R6 status window");

    // R5, R7: individual status lanes
    setIn(1, 0, 1, 0, 0, 2'b01, 0);
    step(0, 1, A_STATUS, "R5 live levels");
    setIn(0, 1, 0, 0, 0, 2'b10, 1);
    step(0, 1, A_STATUS, "R7 comparators adc");

    // R10: read reason in the capture cycle returns the old value
    setIn(1, 1, 0, 0, 0, 2'b00, 0);
    step(1, 1, A_REASON, "R10 read during capture");
    step(0, 1, A_REASON, "R1 new value visible");

    // R9: unmapped addresses
    step(0, 1, 6'h00, "R9 unmapped");
    step(0, 1, 6'h3f, "R9 unmapped");
    step(0, 1, 6'h12, "R9 unmapped");

    // R8: data lasts one cycle only
    step(0, 1, A_STATUS, "R5 status");
    step(0, 0, A_STATUS, "R8 data drops");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      logic st, en;
      int sel;
      setIn($urandom_range(1), $urandom_range(1), $urandom_range(1),
            $urandom_range(1), $urandom_range(1), 2'($urandom_range(3)),
            $urandom_range(1));
      st  = ($urandom_range(7) == 0);
      en  = ($urandom_range(3) != 0);
      sel = $urandom_range(3);
      a   = (sel == 0) ? A_STATUS : (sel == 1) ? ADDR_W'($urandom) : A_REASON;
      if (!en)
        step(st, en, a, "R8 random idle");
      else if (a == A_REASON)
        step(st, en, a, "R2 random reason");
      else if (a == A_STATUS)
        step(st, en, a, "R5 random status");
      else
        step(st, en, a, "R9 random unmapped");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule